// File: doc/BRIEF.md
# Dual-Channel Slot Position Serializer

This block sits between the frame timing logic of an audio serial port and its two sample FIFOs. On every bit strobe it receives the index of the current bit clock within the frame. It places up to two channel windows per direction at bit offsets the user programs. In the transmit direction it pulls words from the transmit FIFO and shifts them out on the serial data pin. In the receive direction it collects bits from the serial input and pushes completed samples into the receive FIFO.

Each direction has its own 32-bit configuration word, so the transmit and receive windows can sit at different places in the frame. Each channel has an enable, a width from 8 to 32 bits, and a start position. A per-direction packed mode carries two samples of 16 bits or less in one FIFO word. FIFO underrun and overrun each raise a one-cycle error pulse.

Top module: `dual_slot_serializer`

## Requirements
- R1: Each 32-bit configuration word holds channel 1 in bits 31:16 and channel 2 in bits 15:0. Each 16-bit half has a width-extend flag at bit 15, an enable at bit 14, the start position at bits 13:4 and a width code at bits 3:0. The width is 8 + code + 16 × extend, so 24 bits and above need extend set.
- R2: On the strobe whose bit index equals an enabled transmit channel's position, `sd_out` takes that sample's most significant bit, counted at the channel width. Each later strobe moves to the next lower bit. `sd_out` is registered and changes at the strobe edge.
- R3: Without packing, each enabled transmit window pops exactly one FIFO word at its first bit. The window sends the low `width` bits of that word.
- R4: A disabled channel pops nothing and sends nothing. On strobes outside every enabled transmit window, `sd_out` is 0.
- R5: With transmit packing, only the channel 1 window pops a word. Channel 1 sends bits 15:0 of that word and channel 2 sends bits 31:16.
- R6: A transmit pop attempt while the FIFO is empty sends an all-zero sample and pulses `tx_urun` for one cycle.
- R7: Without packing, each enabled receive window samples `sd_in` on `width` strobes starting at its position, most significant bit first. The sample is pushed zero-extended one cycle after its last bit.
- R8: With receive packing, the channel 1 sample is held. The channel 2 sample completes one push with channel 2 in bits 31:16 and channel 1 in bits 15:0.
- R9: A completed receive word that meets `rx_full` high is dropped, with no push, and `rx_orun` pulses for one cycle.
- R10: Transmit and receive windows are placed only by their own configuration words and can differ in the same frame.
- R11: After reset, `sd_out`, `tx_pop`, `rx_push`, `tx_urun` and `rx_orun` are all 0.
- R12: Cycles without `bit_stb` leave `sd_out` unchanged, and no receive bit is sampled on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe per bit clock |
| bit_cnt | input | BITCNT_W | Bit index since frame start, valid with `bit_stb` |
| tx_cfg | input | 32 | Transmit channel configuration |
| rx_cfg | input | 32 | Receive channel configuration |
| tx_pack | input | 1 | Transmit packed mode |
| rx_pack | input | 1 | Receive packed mode |
| tx_data | input | 32 | Head word of the transmit FIFO (show-ahead) |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO read, same cycle as the strobe |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Receive FIFO write |
| rx_wdata | output | 32 | Receive FIFO write data |
| tx_urun | output | 1 | Transmit underrun pulse |
| rx_orun | output | 1 | Receive overrun pulse |

## Verification
The bench builds the block with the default 10-bit bit counter and runs 80-bit frames. This leaves room to sweep every pair of six widths (8 to 32, crossing the extend boundary) over four offsets. Transmit uses channel 1 first and receive uses channel 2 first, both in the same frame. A shorter sweep covers packed widths of 8, 11 and 16 bits. Idle cycles are inserted between strobes every few bits, and single frames cover a disabled channel, transmit underrun in both modes, and receive overrun.

// File: rtl/slotser_pkg.sv
package slotser_pkg;

    localparam int HALF_W = 16;
    localparam int POS_W  = 10;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 6;

    typedef struct packed {
        logic             en;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] width;
    } chan_t;

    // Decode one 16-bit channel half: extend | enable | position | code
    function automatic chan_t decode_chan(input logic [HALF_W-1:0] f);
        chan_t    c;
        logic [6:0] w;
        w = 7'd8 + {3'b000, f[3:0]} + (f[15] ? 7'd16 : 7'd0);
        if (w > 7'd32) begin
            w = 7'd32;
        end
        c.en    = f[14];
        c.pos   = f[13:4];
        c.width = w[CNT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/slot_match.sv
module slot_match
    import slotser_pkg::*;
#(
    parameter int BITCNT_W = 10
) (
    input  logic [HALF_W-1:0]   cfg_half,
    input  logic [BITCNT_W-1:0] bit_cnt,
    output logic                hit,
    output logic [CNT_W-1:0]    width
);

    chan_t ch;

    always_comb begin
        ch    = decode_chan(cfg_half);
        hit   = ch.en && (32'(bit_cnt) == 32'(ch.pos));
        width = ch.width;
    end

endmodule

// File: rtl/slot_tx.sv
module slot_tx
    import slotser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              pack,
    input  logic              hit1,
    input  logic              hit2,
    input  logic [CNT_W-1:0]  w1,
    input  logic [CNT_W-1:0]  w2,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              sd_out,
    output logic              tx_urun
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  left;
        logic [HALF_W-1:0] hold;
        logic              sdo;
        logic              urun;
    } tx_st_t;

    tx_st_t d, q;
    logic [WORD_W-1:0] word, samp, al;
    logic [HALF_W-1:0] half;
    logic [CNT_W-1:0]  w;

    always_comb begin
        d      = q;
        d.urun = 1'b0;
        tx_pop = 1'b0;
        word   = '0;
        samp   = '0;
        al     = '0;
        half   = '0;
        w      = '0;
        if (bit_stb) begin
            if (hit1 || hit2) begin
                w = hit1 ? w1 : w2;
                if (!pack || hit1) begin
                    if (!tx_empty) begin
                        tx_pop = 1'b1;
                        word   = tx_data;
                    end else begin
                        d.urun = 1'b1;
                    end
                end
                if (pack) begin
                    half = hit1 ? word[HALF_W-1:0] : q.hold;
                    if (hit1) begin
                        d.hold = word[WORD_W-1:HALF_W];
                    end
                    samp = {{(WORD_W-HALF_W){1'b0}}, half};
                end else begin
                    samp = word;
                end
                al     = samp << (CNT_W'(WORD_W) - w);
                d.sdo  = al[WORD_W-1];
                d.sh   = {al[WORD_W-2:0], 1'b0};
                d.left = w - CNT_W'(1);
            end else if (q.left != '0) begin
                d.sdo  = q.sh[WORD_W-1];
                d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                d.left = q.left - CNT_W'(1);
            end else begin
                d.sdo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sd_out  = q.sdo;
    assign tx_urun = q.urun;

    AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && q.left == '0 && !hit1 && !hit2) |=> !sd_out); // R4
    AST_TX_URUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_urun |-> !sd_out); // R6
    AST_TX_PACK_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && pack) |-> hit1); // R5

endmodule

// File: rtl/slot_rx.sv
module slot_rx
    import slotser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              pack,
    input  logic              hit1,
    input  logic              hit2,
    input  logic [CNT_W-1:0]  w1,
    input  logic [CNT_W-1:0]  w2,
    input  logic              sd_in,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_wdata,
    output logic              rx_orun
);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  left;
        logic              cur2;
        logic [HALF_W-1:0] hold;
        logic              push;
        logic [WORD_W-1:0] wdata;
        logic              orun;
    } rx_st_t;

    rx_st_t d, q;
    logic [WORD_W-1:0] nv, outw;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        d.orun = 1'b0;
        nv     = '0;
        outw   = '0;
        if (bit_stb) begin
            if (hit1 || hit2) begin
                d.acc  = {{(WORD_W-1){1'b0}}, sd_in};
                d.left = (hit1 ? w1 : w2) - CNT_W'(1);
                d.cur2 = !hit1;
            end else if (q.left != '0) begin
                nv     = {q.acc[WORD_W-2:0], sd_in};
                d.acc  = nv;
                d.left = q.left - CNT_W'(1);
                if (q.left == CNT_W'(1)) begin
                    if (pack && !q.cur2) begin
                        d.hold = nv[HALF_W-1:0];
                    end else begin
                        outw = pack ? {nv[HALF_W-1:0], q.hold} : nv;
                        if (rx_full) begin
                            d.orun = 1'b1;
                        end else begin
                            d.push  = 1'b1;
                            d.wdata = outw;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_push  = q.push;
    assign rx_wdata = q.wdata;
    assign rx_orun  = q.orun;

    AST_RX_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(rx_full)); // R9
    AST_RX_PUSH_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(bit_stb)); // R12

endmodule

// File: rtl/dual_slot_serializer.sv
module dual_slot_serializer
    import slotser_pkg::*;
#(
    parameter int BITCNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic [BITCNT_W-1:0] bit_cnt,
    input  logic [31:0]         tx_cfg,
    input  logic [31:0]         rx_cfg,
    input  logic                tx_pack,
    input  logic                rx_pack,
    input  logic [31:0]         tx_data,
    input  logic                tx_empty,
    output logic                tx_pop,
    output logic                sd_out,
    input  logic                sd_in,
    input  logic                rx_full,
    output logic                rx_push,
    output logic [31:0]         rx_wdata,
    output logic                tx_urun,
    output logic                rx_orun
);

    localparam int NCH = 2;

    logic [NCH-1:0]   tx_hit, rx_hit;
    logic [CNT_W-1:0] tx_w [NCH];
    logic [CNT_W-1:0] rx_w [NCH];

    // index 0 is channel 1 (upper half), index 1 is channel 2 (lower half)
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        slot_match #(.BITCNT_W(BITCNT_W)) u_tx_m (
            .cfg_half (tx_cfg[HALF_W*(NCH-1-g) +: HALF_W]),
            .bit_cnt  (bit_cnt),
            .hit      (tx_hit[g]),
            .width    (tx_w[g])
        );
        slot_match #(.BITCNT_W(BITCNT_W)) u_rx_m (
            .cfg_half (rx_cfg[HALF_W*(NCH-1-g) +: HALF_W]),
            .bit_cnt  (bit_cnt),
            .hit      (rx_hit[g]),
            .width    (rx_w[g])
        );
    end

    slot_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .pack     (tx_pack),
        .hit1     (tx_hit[0]),
        .hit2     (tx_hit[1]),
        .w1       (tx_w[0]),
        .w2       (tx_w[1]),
        .tx_data  (tx_data),
        .tx_empty (tx_empty),
        .tx_pop   (tx_pop),
        .sd_out   (sd_out),
        .tx_urun  (tx_urun)
    );

    slot_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .pack     (rx_pack),
        .hit1     (rx_hit[0]),
        .hit2     (rx_hit[1]),
        .w1       (rx_w[0]),
        .w2       (rx_w[1]),
        .sd_in    (sd_in),
        .rx_full  (rx_full),
        .rx_push  (rx_push),
        .rx_wdata (rx_wdata),
        .rx_orun  (rx_orun)
    );

endmodule

// File: tb/dual_slot_serializer_tb.sv
`timescale 1ns/1ps
module dual_slot_serializer_tb;

    localparam int FL = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic [9:0]  bit_cnt = '0;
    logic [31:0] tx_cfg = '0, rx_cfg = '0;
    logic        tx_pack = 1'b0, rx_pack = 1'b0;
    logic [31:0] tx_data;
    logic        tx_empty;
    logic        tx_pop, sd_out, rx_push, tx_urun, rx_orun;
    logic        sd_in = 1'b0;
    logic        rx_full = 1'b0;
    logic [31:0] rx_wdata;

    int total = 0, bad = 0;
    int rd = 0, avail = 0;
    int ngot = 0, urun_cnt = 0, orun_cnt = 0;
    logic [31:0] got [0:15];
    logic [95:0] pat;

    always #10 clk = ~clk;

    function automatic logic [31:0] qw(input int i);
        return 32'h1234_5678 ^ (32'(i + 1) * 32'h9E37_79B9);
    endfunction

    assign tx_empty = (rd >= avail);
    assign tx_data  = qw(rd);

    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_pop)  rd <= rd + 1;
            if (rx_push) begin
                got[ngot % 16] <= rx_wdata;
                ngot <= ngot + 1;
            end
            if (tx_urun) urun_cnt <= urun_cnt + 1;
            if (rx_orun) orun_cnt <= orun_cnt + 1;
        end
    end

    dual_slot_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_cnt(bit_cnt),
        .tx_cfg(tx_cfg), .rx_cfg(rx_cfg), .tx_pack(tx_pack), .rx_pack(rx_pack),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop), .sd_out(sd_out),
        .sd_in(sd_in), .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .tx_urun(tx_urun), .rx_orun(rx_orun)
    );

    task automatic chk(input bit ok, input string req, input string ctx,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, ctx, act, exp);
        end
    endtask

    // channel half: extend | enable | position | width code (R1)
    function automatic logic [15:0] enc(input int en, input int pos, input int w);
        logic       x;
        logic [3:0] c;
        x = (w >= 24);
        c = 4'(w - 8 - (x ? 16 : 0));
        return {x, (en != 0), 10'(pos), c};
    endfunction

    function automatic logic [31:0] ext_bits(input int pos, input int w);
        logic [31:0] v = '0;
        for (int i = 0; i < w; i++) v = {v[30:0], pat[pos + i]};
        return v;
    endfunction

    function automatic int wl(input int i);
        case (i)
            0: return 8;  1: return 12; 2: return 16;
            3: return 20; 4: return 24; default: return 32;
        endcase
    endfunction

    task automatic run_frame(
        input int t1e, input int t1p, input int t1w,
        input int t2e, input int t2p, input int t2w,
        input int r1e, input int r1p, input int r1w,
        input int r2e, input int r2p, input int r2w,
        input bit tp, input bit rp, input bit full,
        input int avail_extra, input string tag);
        int eidx, eurun, eorun, nexp, u0, o0, g0;
        logic [31:0] s1, s2, word, v, expv [0:3];
        logic [15:0] eh, rh;
        logic e, prev;
        @(negedge clk);
        tx_cfg  = {enc(t1e, t1p, t1w), enc(t2e, t2p, t2w)};
        rx_cfg  = {enc(r1e, r1p, r1w), enc(r2e, r2p, r2w)};
        tx_pack = tp; rx_pack = rp; rx_full = full;
        avail   = rd + avail_extra;
        pat     = {$urandom, $urandom, $urandom};
        eidx = rd; eurun = 0; s1 = '0; s2 = '0; eh = '0;
        u0 = urun_cnt; o0 = orun_cnt; g0 = ngot;
        for (int k = 0; k < FL; k++) begin
            if (k % 5 == 4) begin
                @(negedge clk);
                bit_stb = 1'b0;
                sd_in = ~pat[k];
                prev = sd_out;
                @(posedge clk); #1;
                chk(sd_out == prev, "R12", tag, 32'(sd_out), 32'(prev));
            end
            @(negedge clk);
            bit_cnt = 10'(k); bit_stb = 1'b1; sd_in = pat[k];
            if (t1e != 0 && k == t1p) begin
                if (eidx < avail) begin word = qw(eidx); eidx++; end
                else begin word = '0; eurun++; end
                s1 = tp ? {16'b0, word[15:0]} : word;
                if (tp) eh = word[31:16];
            end else if (t2e != 0 && k == t2p) begin
                if (tp) s2 = {16'b0, eh};
                else begin
                    if (eidx < avail) begin word = qw(eidx); eidx++; end
                    else begin word = '0; eurun++; end
                    s2 = word;
                end
            end
            e = 1'b0;
            if (t1e != 0 && k >= t1p && k < t1p + t1w) e = s1[t1w - 1 - (k - t1p)];
            else if (t2e != 0 && k >= t2p && k < t2p + t2w) e = s2[t2w - 1 - (k - t2p)];
            @(posedge clk); #1;
            chk(sd_out == e, "R2", tag, 32'(sd_out), 32'(e));
        end
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(rd == eidx, "R3", tag, 32'(rd), 32'(eidx));
        chk(urun_cnt - u0 == eurun, "R6", tag, 32'(urun_cnt - u0), 32'(eurun));
        // receive expectation in time order of the windows
        nexp = 0; eorun = 0; rh = '0;
        for (int s = 0; s < 2; s++) begin
            int c, en, pos, w;
            c   = ((s == 0) == (r1p <= r2p)) ? 1 : 2;
            en  = (c == 1) ? r1e : r2e;
            pos = (c == 1) ? r1p : r2p;
            w   = (c == 1) ? r1w : r2w;
            if (en != 0) begin
                v = ext_bits(pos, w);
                if (rp && c == 1) rh = v[15:0];
                else if (full) eorun++;
                else begin
                    expv[nexp] = rp ? {v[15:0], rh} : v;
                    nexp++;
                end
            end
        end
        chk(ngot - g0 == nexp, "R7", tag, 32'(ngot - g0), 32'(nexp));
        chk(orun_cnt - o0 == eorun, "R9", tag, 32'(orun_cnt - o0), 32'(eorun));
        for (int i = 0; i < nexp && i < ngot - g0; i++)
            chk(got[(g0 + i) % 16] == expv[i], "R7", tag, got[(g0 + i) % 16], expv[i]);
    endtask

    initial begin
        #4_000_000;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(sd_out == 1'b0, "R11", "reset sd_out", 32'(sd_out), 0);
        chk(tx_pop == 1'b0 && rx_push == 1'b0, "R11", "reset pop/push",
            32'({tx_pop, rx_push}), 0);
        chk(tx_urun == 1'b0 && rx_orun == 1'b0, "R11", "reset flags",
            32'({tx_urun, rx_orun}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // non-packed sweep, transmit ch1 first, receive ch2 first (R1 R10)
        for (int wi = 0; wi < 6; wi++)
            for (int wj = 0; wj < 6; wj++)
                for (int pj = 0; pj < 4; pj++)
                    run_frame(1, pj, wl(wi), 1, pj + wl(wi) + pj, wl(wj),
                              1, pj + wl(wi) + 1, wl(wj), 1, pj, wl(wi),
                              1'b0, 1'b0, 1'b0, 100, "R1 R10 sweep");

        // packed sweep (R5 R8)
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int pj = 0; pj < 4; pj++) begin
                    int wa, wb;
                    wa = (a == 0) ? 8 : (a == 1) ? 11 : 16;
                    wb = (b == 0) ? 8 : (b == 1) ? 11 : 16;
                    run_frame(1, pj, wa, 1, 40 + pj, wb,
                              1, 2 * pj, wb, 1, 50 - pj, wa,
                              1'b1, 1'b1, 1'b0, 100, "R5 R8 packed");
                end

        // disabled channels (R4)
        run_frame(1, 10, 16, 0, 40, 16, 0, 5, 16, 1, 30, 12,
                  1'b0, 1'b0, 1'b0, 100, "R4 disabled");
        run_frame(0, 10, 16, 0, 40, 16, 0, 5, 16, 0, 30, 12,
                  1'b0, 1'b0, 1'b0, 100, "R4 all off");
        // underrun, plain and packed (R6)
        run_frame(1, 2, 16, 1, 30, 24, 0, 0, 8, 0, 0, 8,
                  1'b0, 1'b0, 1'b0, 1, "R6 underrun");
        run_frame(1, 0, 16, 1, 20, 16, 0, 0, 8, 0, 0, 8,
                  1'b1, 1'b0, 1'b0, 0, "R6 packed underrun");
        // overrun, plain and packed (R9)
        run_frame(0, 0, 8, 0, 0, 8, 1, 3, 32, 1, 40, 8,
                  1'b0, 1'b0, 1'b1, 100, "R9 overrun");
        run_frame(0, 0, 8, 0, 0, 8, 1, 3, 16, 1, 40, 16,
                  1'b0, 1'b1, 1'b1, 100, "R9 packed overrun");
        // back-to-back windows at the top of the frame (R2)
        run_frame(1, 16, 32, 1, 48, 32, 1, 0, 32, 1, 32, 32,
                  1'b0, 1'b0, 1'b0, 100, "R2 adjacent");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule